// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is a 32-bit execute stage. It holds a file of four general registers and a status word. Each cycle in which `op_valid` is high, it applies one operation to a destination register and a source operand. The operations are add, subtract, compare, OR, XOR and bit-test.

On the same rising edge, the arithmetic and logic operations write their result back to the destination register. On that edge the block also replaces the zero, negative, carry and overflow flags of the status word. Compare and bit-test only change the flags. Status bits above the four flags are never touched by an operation.

Register contents can be read at any time through a separate combinational read port. The whole status word is visible as an output, so a surrounding pipeline can branch on the flags or inspect results.

Top module: `flag_alu`

## Requirements
- R1: Operation code 0 (add) writes destination plus source, modulo 2^32, to the destination register. Carry (status bit 2) is set exactly when the true sum exceeds 32 bits.
- R2: For add, overflow (status bit 3) is set when source and destination have equal bit 31 and the sum's bit 31 differs from the destination's.
- R3: Operation code 1 (subtract) writes destination minus source. Carry is set when source is greater than destination as unsigned numbers. Overflow is set when the operands' bit 31 differ and the result's bit 31 differs from the destination's.
- R4: Operation code 2 (compare) computes destination minus source and sets all four flags by the subtract rules. It leaves every register unchanged.
- R5: Operation codes 3 (OR) and 4 (XOR) write the bitwise result to the destination and clear carry and overflow.
- R6: Operation code 5 (bit-test) ANDs source with the destination register. It sets zero and negative from the AND, clears carry and overflow, and writes no register.
- R7: For codes 0 to 5, zero (status bit 0) is set exactly when the 32-bit result is 0. Negative (status bit 1) equals bit 31 of the result. No flag keeps its old value.
- R8: While `op_valid` is low, no register and no status bit changes.
- R9: Status bits 4 and above are never altered by any operation.
- R10: A synchronous active-high `rst` clears all registers and the whole status word at the next rising edge.
- R11: Operation codes 6 and 7 change neither registers nor status bits, even with `op_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Perform the presented operation at this edge |
| op_code | input | 3 | Operation select (0 add, 1 sub, 2 cmp, 3 or, 4 xor, 5 bit-test) |
| src_data | input | 32 | Source operand |
| dst_sel | input | 2 | Destination register index |
| rd_sel | input | 2 | Read-port register index |
| rd_data | output | 32 | Contents of register `rd_sel` |
| status_word | output | 8 | Status word, flags Z=0, N=1, C=2, V=3 |

## Verification
The hardest conditions to reach are the signed-overflow cases, because they need operands near the signed boundary. The 0x80000000 + 0x80000000 case, which sets zero, carry and overflow together, is one of them. Since all registers start at zero, the stimulus table first builds such operands in a register with chained adds and subtracts. It then drives the boundary operation and checks the destination and the full status word after each step. Flag-only operations are checked by reading the destination back to confirm it is unchanged. A preceding subtract leaves carry set, so a logic operation that follows shows that it clears carry.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    localparam int FLAG_W = 4;
    localparam int FLAG_Z = 0;
    localparam int FLAG_N = 1;
    localparam int FLAG_C = 2;
    localparam int FLAG_V = 3;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_BTST = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    // Packed so that z lands on bit 0 and v on bit 3.
    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } alu_flags_t;

    function automatic logic op_writes_dest(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic op_sets_flags(alu_op_e op);
        return (op != OP_RSV6) && (op != OP_RSV7);
    endfunction

    function automatic logic op_is_logical(alu_op_e op);
        return (op == OP_OR) || (op == OP_XOR) || (op == OP_BTST);
    endfunction

endpackage

// File: rtl/flag_alu_exec.sv
module flag_alu_exec
    import flag_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    output logic [DATA_W-1:0] result,
    output alu_flags_t        flags,
    output logic              wr_req,
    output logic              flag_req
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   sum_ext;
    logic [DATA_W:0]   diff_ext;
    logic [DATA_W-1:0] res_int;
    logic              carry_int;
    logic              ovf_int;

    always_comb begin
        sum_ext  = {1'b0, dst_val} + {1'b0, src_val};
        diff_ext = {1'b0, dst_val} - {1'b0, src_val};
        res_int   = '0;
        carry_int = 1'b0;
        ovf_int   = 1'b0;
        unique case (op)
            OP_ADD: begin
                res_int   = sum_ext[MSB:0];
                carry_int = sum_ext[DATA_W];
                ovf_int   = (dst_val[MSB] == src_val[MSB]) && (res_int[MSB] != dst_val[MSB]);
            end
            OP_SUB, OP_CMP: begin
                res_int   = diff_ext[MSB:0];
                carry_int = diff_ext[DATA_W];
                ovf_int   = (dst_val[MSB] != src_val[MSB]) && (res_int[MSB] != dst_val[MSB]);
            end
            OP_OR:   res_int = dst_val | src_val;
            OP_XOR:  res_int = dst_val ^ src_val;
            OP_BTST: res_int = dst_val & src_val;
            default: res_int = '0;
        endcase
    end

    assign result   = res_int;
    assign flags.z  = (res_int == '0);
    assign flags.n  = res_int[MSB];
    assign flags.c  = carry_int;
    assign flags.v  = ovf_int;
    assign wr_req   = op_writes_dest(op);
    assign flag_req = op_sets_flags(op);

endmodule

// File: rtl/flag_alu_regfile.sv
module flag_alu_regfile #(
    parameter int DATA_W = 32,
    parameter int REG_N  = 4,
    localparam int IDX_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  dst_idx,
    output logic [DATA_W-1:0] dst_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] regs_q [REG_N];

    for (genvar gi = 0; gi < REG_N; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[gi] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                regs_q[gi] <= wr_data;
            end
        end

        // R4
        reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && (wr_idx == IDX_W'(gi))) |=> $stable(regs_q[gi]));
    end

    assign dst_data = regs_q[dst_idx];
    assign rd_data  = regs_q[rd_idx];

endmodule

// File: rtl/flag_alu_status.sv
module flag_alu_status
    import flag_alu_pkg::*;
#(
    parameter int STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                upd,
    input  alu_flags_t          flags_in,
    output logic [STATUS_W-1:0] status_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else if (upd) begin
            status_q[FLAG_W-1:0] <= flags_in;
        end
    end

    // R8
    idle_status_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(status_q));

    // R9
    upper_bits_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(status_q[STATUS_W-1:FLAG_W]));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (status_q == '0));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int REG_N    = 4,
    parameter int STATUS_W = 8,
    localparam int IDX_W   = $clog2(REG_N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [2:0]          op_code,
    input  logic [DATA_W-1:0]   src_data,
    input  logic [IDX_W-1:0]    dst_sel,
    input  logic [IDX_W-1:0]    rd_sel,
    output logic [DATA_W-1:0]   rd_data,
    output logic [STATUS_W-1:0] status_word
);

    alu_op_e           op;
    logic [DATA_W-1:0] dst_val;
    logic [DATA_W-1:0] exec_result;
    alu_flags_t        exec_flags;
    logic              exec_wr;
    logic              exec_flag;
    logic              rf_wr_en;
    logic              st_upd;

    assign op       = alu_op_e'(op_code);
    assign rf_wr_en = op_valid && exec_wr;
    assign st_upd   = op_valid && exec_flag;

    flag_alu_regfile #(.DATA_W(DATA_W), .REG_N(REG_N)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rf_wr_en),
        .wr_idx   (dst_sel),
        .wr_data  (exec_result),
        .dst_idx  (dst_sel),
        .dst_data (dst_val),
        .rd_idx   (rd_sel),
        .rd_data  (rd_data)
    );

    flag_alu_exec #(.DATA_W(DATA_W)) u_exec (
        .op       (op),
        .src_val  (src_data),
        .dst_val  (dst_val),
        .result   (exec_result),
        .flags    (exec_flags),
        .wr_req   (exec_wr),
        .flag_req (exec_flag)
    );

    flag_alu_status #(.STATUS_W(STATUS_W)) u_status (
        .clk      (clk),
        .rst      (rst),
        .upd      (st_upd),
        .flags_in (exec_flags),
        .status_q (status_word)
    );

    // R6 (compare likewise, R4)
    no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && ((op_code == 3'd2) || (op_code == 3'd5))) |-> !rf_wr_en);

    // R5
    logic_cv_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_is_logical(op)) |=> (!status_word[FLAG_C] && !status_word[FLAG_V]));

    // R11
    unused_op_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_code[2:1] == 2'b11)) |=> $stable(status_word));

endmodule

// File: tb/flag_alu_tb.sv
module flag_alu_tb_top;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  dst;
        logic [31:0] src;
        logic [31:0] exp_val;
        logic [3:0]  exp_flags;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd1, 32'h7FFFFFFF, 32'h7FFFFFFF, 4'h0},
        '{3'd0, 2'd1, 32'h00000001, 32'h80000000, 4'hA},
        '{3'd0, 2'd1, 32'h80000000, 32'h00000000, 4'hD},
        '{3'd0, 2'd2, 32'h00000005, 32'h00000005, 4'h0},
        '{3'd1, 2'd2, 32'h00000007, 32'hFFFFFFFE, 4'h6},
        '{3'd1, 2'd2, 32'hFFFFFFFE, 32'h00000000, 4'h1},
        '{3'd0, 2'd3, 32'h80000000, 32'h80000000, 4'h2},
        '{3'd1, 2'd3, 32'h00000001, 32'h7FFFFFFF, 4'h8},
        '{3'd2, 2'd3, 32'h7FFFFFFF, 32'h7FFFFFFF, 4'h1},
        '{3'd2, 2'd3, 32'h80000000, 32'h7FFFFFFF, 4'hE},
        '{3'd3, 2'd0, 32'h000000F0, 32'h000000F0, 4'h0},
        '{3'd4, 2'd0, 32'h000000F0, 32'h00000000, 4'h1},
        '{3'd3, 2'd0, 32'h80000001, 32'h80000001, 4'h2},
        '{3'd5, 2'd0, 32'h00000001, 32'h80000001, 4'h0},
        '{3'd5, 2'd0, 32'h7FFFFFFE, 32'h80000001, 4'h1},
        '{3'd5, 2'd0, 32'h80000000, 32'h80000001, 4'h2},
        '{3'd1, 2'd2, 32'h00000001, 32'hFFFFFFFF, 4'h6},
        '{3'd3, 2'd2, 32'h00000000, 32'hFFFFFFFF, 4'h2},
        '{3'd4, 2'd2, 32'hFFFFFFFF, 32'h00000000, 4'h1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [2:0]  op_code = '0;
    logic [31:0] src_data = '0;
    logic [1:0]  dst_sel = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    logic [7:0]  status_word;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    flag_alu dut_i (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .src_data    (src_data),
        .dst_sel     (dst_sel),
        .rd_sel      (rd_sel),
        .rd_data     (rd_data),
        .status_word (status_word)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic string req_of(logic [2:0] op);
        case (op)
            3'd0:    return "R1 R2 R7";
            3'd1:    return "R3 R7";
            3'd2:    return "R4 R7";
            3'd5:    return "R6 R7";
            default: return "R5 R7";
        endcase
    endfunction

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic run_op(logic valid, logic [2:0] op, logic [1:0] dst, logic [31:0] src);
        @(negedge clk);
        op_valid = valid;
        op_code  = op;
        dst_sel  = dst;
        src_data = src;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic read_reg(logic [1:0] idx, output logic [31:0] val);
        rd_sel = idx;
        #1;
        val = rd_data;
    endtask

    task automatic check_all_clear(string req);
        logic [31:0] v;
        for (int i = 0; i < 4; i++) begin
            read_reg(2'(i), v);
            check(req, v, 32'h0);
        end
        check(req, {24'h0, status_word}, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R10: state after reset
        check_all_clear("R10 reset");

        foreach (VEC[k]) begin
            run_op(1'b1, VEC[k].op, VEC[k].dst, VEC[k].src);
            read_reg(VEC[k].dst, v);
            check(req_of(VEC[k].op), v, VEC[k].exp_val);
            // R9: bits above the flags stay zero
            check({req_of(VEC[k].op), " R9"}, {24'h0, status_word}, {28'h0, VEC[k].exp_flags});
        end

        // R8: idle cycle with an add presented
        run_op(1'b0, 3'd0, 2'd2, 32'h5);
        read_reg(2'd2, v);
        check("R8 reg", v, 32'h0);
        check("R8 flags", {24'h0, status_word}, 32'h1);

        // R11: reserved codes with valid high
        run_op(1'b1, 3'd6, 2'd2, 32'h3);
        read_reg(2'd2, v);
        check("R11 code6 reg", v, 32'h0);
        check("R11 code6 flags", {24'h0, status_word}, 32'h1);
        run_op(1'b1, 3'd7, 2'd2, 32'hFFFFFFFF);
        read_reg(2'd2, v);
        check("R11 code7 reg", v, 32'h0);
        check("R11 code7 flags", {24'h0, status_word}, 32'h1);

        // Other registers kept their values through the run (R4 R6)
        read_reg(2'd3, v);
        check("R4 r3 kept", v, 32'h7FFFFFFF);
        read_reg(2'd0, v);
        check("R6 r0 kept", v, 32'h80000001);

        // R10: reset in mid-run after leaving carry set
        run_op(1'b1, 3'd1, 2'd1, 32'h1);
        check("R3 pre-reset flags", {24'h0, status_word}, 32'h6);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_all_clear("R10 mid-run");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule